// File: doc/BRIEF.md
# Five-Function Integer ALU with Zero Detect

This block is the arithmetic and logic core of a single-cycle integer datapath. It takes two 32-bit operands and a 3-bit function select. It returns a 32-bit result and a flag that marks an all-zero result. The block has no state, so a result follows its inputs within the same cycle.

The datapath control picks the function. Memory address generation uses addition. Branch-on-equal uses subtraction followed by a test of the zero flag. Register-to-register instructions use any of the five functions. Operations wrap silently. The set-on-less-than function compares the operands as two's-complement numbers.

Top module: `alu3_top`

## Requirements
- R1: Select code 3'b000 drives the bitwise AND of the two operands onto the result.
- R2: Select code 3'b001 drives the bitwise OR of the two operands onto the result.
- R3: Select code 3'b010 drives the sum of the operands modulo 2^WIDTH onto the result, with no flag raised on carry or overflow.
- R4: Select code 3'b110 drives operand A minus operand B, modulo 2^WIDTH, onto the result.
- R5: Select code 3'b111 drives 1 onto the result when A is less than B as signed two's-complement values, and 0 otherwise. All result bits above bit 0 are always zero for this code. The comparison is correct at the extremes, for example when 0x80000000 is compared with 1, or 0x7FFFFFFF is compared with 0x80000000.
- R6: The zero output is 1 exactly when every bit of the result is 0.
- R7: The unused select codes 3'b011, 3'b100 and 3'b101 drive a result of all zeros, so the zero output is 1 for them.
- R8: Under select code 3'b110, the zero output is 1 exactly when the two operands are equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand (minuend for subtract) |
| b_i | input | WIDTH | Second operand (subtrahend for subtract) |
| op_i | input | 3 | Function select code |
| result_o | output | WIDTH | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
Both outputs are purely combinational, so each result is due in the same cycle as its stimulus, with zero register stages. The driver applies operands and a select code just after a rising edge and queues the expected pair. The monitor compares at the following falling edge, half a period later, once the logic has settled and before the next stimulus. The signed-compare extremes, the wrap of add and subtract, and the three unused codes are applied as directed vectors, ahead of pseudo-random ones.

// File: rtl/alu3_pkg.sv
package alu3_pkg;
  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;
endpackage

// File: rtl/alu3_logic.sv
module alu3_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    assign and_o[g] = a_i[g] & b_i[g];
    assign or_o[g]  = a_i[g] | b_i[g];
  end
endmodule

// File: rtl/alu3_addsub.sv
module alu3_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;

  // subtract as a + ~b + 1
  assign b_eff = sub_i ? ~b_i : b_i;
  assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
  assign sum_o = full[MSB:0];
  assign ovf_o = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
endmodule

// File: rtl/alu3_slt.sv
module alu3_slt #(
  parameter int WIDTH = 32
) (
  input  logic             diff_msb_i,
  input  logic             ovf_i,
  output logic [WIDTH-1:0] lt_o
);
  // sign of a-b, corrected when the subtraction overflowed
  assign lt_o = {{(WIDTH-1){1'b0}}, diff_msb_i ^ ovf_i};
endmodule

// File: rtl/alu3_top.sv
module alu3_top
  import alu3_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o
);
  logic [WIDTH-1:0] and_w, or_w, sum_w, lt_w;
  logic             ovf_w;
  logic             sub_w;

  // bit 2 of the code is set for both subtract and compare
  assign sub_w = op_i[2];

  alu3_logic #(.WIDTH(WIDTH)) logic_i (
    .a_i   (a_i),
    .b_i   (b_i),
    .and_o (and_w),
    .or_o  (or_w)
  );

  alu3_addsub #(.WIDTH(WIDTH)) addsub_i (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (sub_w),
    .sum_o (sum_w),
    .ovf_o (ovf_w)
  );

  alu3_slt #(.WIDTH(WIDTH)) slt_i (
    .diff_msb_i (sum_w[WIDTH-1]),
    .ovf_i      (ovf_w),
    .lt_o       (lt_w)
  );

  always_comb begin
    case (op_i)
      OP_AND:  result_o = and_w;
      OP_OR:   result_o = or_w;
      OP_ADD,
      OP_SUB:  result_o = sum_w;
      OP_SLT:  result_o = lt_w;
      default: result_o = '0;
    endcase
  end

  assign zero_o = ~|result_o;
endmodule

// File: rtl/alu3_chk.sv
module alu3_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o
);
  always_comb begin
    if (op_i == 3'b000) begin
      assert_and_subset_R1: assert ((result_o & ~a_i) == '0 && (result_o & ~b_i) == '0)
        else $error("and result has bits outside both operands");
    end
    if (op_i == 3'b001) begin
      assert_or_superset_R2: assert ((a_i & ~result_o) == '0 && (b_i & ~result_o) == '0)
        else $error("or result misses operand bits");
    end
    if (op_i == 3'b010) begin
      assert_add_inverse_R3: assert (result_o - b_i == a_i)
        else $error("add result inconsistent");
    end
    if (op_i == 3'b110) begin
      assert_sub_inverse_R4: assert (result_o + b_i == a_i)
        else $error("sub result inconsistent");
      assert_sub_equal_R8: assert (zero_o == (a_i == b_i))
        else $error("zero flag does not match equality");
    end
    if (op_i == 3'b111) begin
      assert_slt_boolean_R5: assert (result_o[WIDTH-1:1] == '0)
        else $error("slt upper bits set");
      assert_slt_match_R5: assert (result_o[0] == ($signed(a_i) < $signed(b_i)))
        else $error("slt wrong");
    end
    if (op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101) begin
      assert_unused_quiet_R7: assert (result_o == '0 && zero_o)
        else $error("unused code drives output");
    end
    if (zero_o) begin
      assert_zero_flag_R6: assert (result_o == '0)
        else $error("zero flag with nonzero result");
    end
  end
endmodule

bind alu3_top alu3_chk #(.WIDTH(WIDTH)) chk_i (
  .a_i      (a_i),
  .b_i      (b_i),
  .op_i     (op_i),
  .result_o (result_o),
  .zero_o   (zero_o)
);

// File: tb/alu3_top_tb_top.sv
module alu3_top_tb_top;
  localparam int WIDTH      = 32;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  typedef struct {
    logic [WIDTH-1:0] a;
    logic [WIDTH-1:0] b;
    logic [2:0]       op;
    logic [WIDTH-1:0] exp_res;
    logic             exp_zero;
  } item_t;

  logic             clk;
  logic [WIDTH-1:0] a_s, b_s;
  logic [2:0]       op_s;
  logic [WIDTH-1:0] result_w;
  logic             zero_w;

  item_t q[$];
  int    n_vec  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  logic [31:0] seed = 32'h1234_5679;

  alu3_top #(.WIDTH(WIDTH)) dut_i (
    .a_i      (a_s),
    .b_i      (b_s),
    .op_i     (op_s),
    .result_o (result_w),
    .zero_o   (zero_w)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string req_of(logic [2:0] op, logic [WIDTH-1:0] a, logic [WIDTH-1:0] b);
    case (op)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return (a == b) ? "R8" : "R4";
      3'b111: return "R5";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [WIDTH-1:0] model(logic [2:0] op, logic [WIDTH-1:0] a, logic [WIDTH-1:0] b);
    case (op)
      3'b000: return a & b;
      3'b001: return a | b;
      3'b010: return a + b;
      3'b110: return a - b;
      3'b111: return ($signed(a) < $signed(b)) ? 1 : 0;
      default: return '0;
    endcase
  endfunction

  task automatic drive(logic [2:0] op, logic [WIDTH-1:0] a, logic [WIDTH-1:0] b);
    item_t it;
    @(posedge clk);
    #1;
    a_s  = a;
    b_s  = b;
    op_s = op;
    it.a = a; it.b = b; it.op = op;
    it.exp_res  = model(op, a, b);
    it.exp_zero = (it.exp_res == '0);  // R6
    q.push_back(it);
  endtask

  function automatic logic [31:0] next_rand(logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // monitor: results are combinational, due half a cycle after drive
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_vec++;
      if (result_w !== it.exp_res) begin
        n_fail++;
        $display("FAIL %s op=%b a=%h b=%h result actual=%h expected=%h",
                 req_of(it.op, it.a, it.b), it.op, it.a, it.b, result_w, it.exp_res);
      end
      if (zero_w !== it.exp_zero) begin
        n_fail++;
        $display("FAIL %s/R6 op=%b a=%h b=%h zero actual=%b expected=%b",
                 req_of(it.op, it.a, it.b), it.op, it.a, it.b, zero_w, it.exp_zero);
      end
    end
  end

  initial begin
    logic [WIDTH-1:0] ca [10];
    logic [WIDTH-1:0] cb [10];
    a_s = '0; b_s = '0; op_s = 3'b000;
    ca[0] = 32'h0000_0000; cb[0] = 32'h0000_0000;
    ca[1] = 32'hFFFF_FFFF; cb[1] = 32'h0000_0001;
    ca[2] = 32'h8000_0000; cb[2] = 32'h0000_0001;
    ca[3] = 32'h0000_0001; cb[3] = 32'h8000_0000;
    ca[4] = 32'h7FFF_FFFF; cb[4] = 32'h8000_0000;
    ca[5] = 32'h8000_0000; cb[5] = 32'h7FFF_FFFF;
    ca[6] = 32'h7FFF_FFFF; cb[6] = 32'hFFFF_FFFF;
    ca[7] = 32'hDEAD_BEEF; cb[7] = 32'hDEAD_BEEF;
    ca[8] = 32'h0F0F_00FF; cb[8] = 32'h00FF_F0F0;
    ca[9] = 32'hFFFF_FFFE; cb[9] = 32'hFFFF_FFFF;
    // initial idle state: AND of zeros -> 0, zero flag high (R1, R6)
    drive(3'b000, '0, '0);
    // directed corners across every select code, incl. unused R7 codes
    for (int op = 0; op < 8; op++) begin
      for (int k = 0; k < 10; k++) begin
        drive(op[2:0], ca[k], cb[k]);
      end
    end
    // wrap cases: R3 add overflow, R4 sub underflow
    drive(3'b010, 32'hFFFF_FFFF, 32'h0000_0001);
    drive(3'b110, 32'h0000_0000, 32'h0000_0001);
    // pseudo-random vectors for R1..R5, R8 equal-operand subtracts
    for (int i = 0; i < 400; i++) begin
      logic [WIDTH-1:0] ra, rb;
      logic [2:0] rop;
      seed = next_rand(seed); ra = seed;
      seed = next_rand(seed); rb = seed;
      seed = next_rand(seed); rop = seed[2:0];
      if (i % 16 == 0) rb = ra;
      drive(rop, ra, rb);
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule